// File: doc/BRIEF.md
# System Bus Read Decoder

This block answers CPU read requests on a handheld console's system bus. It takes a 32-bit address, an access size and a signed flag. From the top address byte it picks one of the memory regions, folds the offset through that region's mirror mask and fetches an aligned 32-bit word. It then cuts the requested byte, halfword or word out of that word, rotating or sign-extending it as the access needs. The answer is registered and appears one cycle after the request, together with a valid strobe.

The region memories are modelled as deterministic content stores, so a read of any offset has a known value. A guard word stands in for boot-ROM reads made while the CPU runs outside boot ROM. In video RAM the upper 32 KB bank is folded down, and the bitmap display modes leave a dead zone that reads as zero. Addresses that decode to nothing return open-bus data. That data is the last DMA word, or else the opcode the CPU is fetching.

Top module: `bus_rd_decode`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after each cycle with `req` high. `rd_data` is loaded from that request and holds its value while no request is made. Synchronous reset clears both to zero.
- R2: Address bits [31:24] pick the region: 0 boot ROM, 2 work RAM, 3 internal RAM, 4 I/O, 5 palette, 6 video RAM, 7 object memory, 8 to 12 cartridge ROM, 13 EEPROM, 14 save memory. Store content is C(id,off) = {w[7:0], w[23:0]} ^ (id << 28) ^ 0x5A3C9600, where w = off[24:2] zero-extended. The id is the region number, except that all five cartridge regions use id 8.
- R3: The offset is the address ANDed with a region mask: 0x3FFF for boot ROM, 0x3FFFF for work RAM, 0x7FFF for internal RAM, 0x3FF for I/O, palette and object memory, and 0x1FFFFFF for cartridge ROM.
- R4: When `pc[31:24]` is nonzero, a boot-ROM read below 0x4000 takes its word from `guard_word`. A boot-region read at 0x4000 or above is then unmapped.
- R5: The video-RAM offset is addr & 0x1FFFF. If `disp_mode` > 2 and offset bits [16:14] = 3'b110, the word is zero. Otherwise, when offset bits [16:15] are both 1, bit 15 is cleared.
- R6: I/O is mapped only below 0x04000400. `io_readable[i]` covers the halfword at I/O offset 2i. Byte and halfword reads need the flag of their own halfword. Word reads need the flag of the lower half. When the upper-half flag is clear, a word read keeps only the low 16 bits. Anything else in I/O is unmapped.
- R7: A word read (size 2, or size 3, which behaves as a word) returns the aligned word rotated right by 8 × addr[1:0]. The signed flag has no effect on it.
- R8: A halfword read (size 1) takes the half chosen by addr[1]. At an odd address the unsigned result is {h[7:0], 16'h0, h[15:8]}.
- R9: With the signed flag, an odd halfword read returns h[15:8] sign-extended, an even one returns h sign-extended, and a byte read (size 0) returns its byte sign-extended. Unsigned bytes are zero-extended, and the byte is chosen by addr[1:0].
- R10: An unmapped read uses an open-bus word. This is `dma_last` when `dma_ovr` is set. Otherwise, in 32-bit state (`cpu_narrow` = 0), it is the store word at `pc`. In 16-bit state it is the halfword chosen by pc[1], placed in both halves. The opcode lookup uses `pc`'s region with that region's mask (video RAM 0x1FFFF, unlisted regions 0) and no guard, fold or hole. The word is then cut down like any other word.
- R11: Region 13 returns all-ones when `nv_eeprom_en` is set, and region 14 returns all-ones when `nv_flash_en` is set. Otherwise each is unmapped. Region 1 and regions 15 to 255 are always unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request strobe |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_signed | input | 1 | Sign-extend byte or halfword result |
| pc | input | 32 | Current fetch address of the CPU |
| cpu_narrow | input | 1 | CPU is in 16-bit instruction state |
| disp_mode | input | 3 | Display mode field |
| dma_ovr | input | 1 | Open bus returns last DMA word |
| dma_last | input | 32 | Last DMA transfer word |
| guard_word | input | 32 | Latched word for guarded boot-ROM reads |
| io_readable | input | IO_FLAGS | Per-halfword I/O readable flags |
| nv_eeprom_en | input | 1 | EEPROM device present |
| nv_flash_en | input | 1 | Save RAM or flash present |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The block keeps no state apart from its output register, so any decode fault shows up at `rd_data` in the very cycle `rd_valid` rises for the request that hit it. No later request can hide it. A wrong mirror mask, fold or guard choice returns the content of a different offset, and the content formula makes every such offset distinguishable. A wrong rotation or extension shows up as shuffled bytes or wrong upper bits. Aliased addresses, bank edges, every byte lane and each open-bus source are read back to back, so each fault is seen at its first use.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        SRC_STORE,
        SRC_GUARD,
        SRC_ZERO,
        SRC_ONES,
        SRC_OPEN
    } word_src_e;

    typedef struct packed {
        word_src_e   src;
        logic [3:0]  id;
        logic [24:0] off;
        logic        low_only;
    } lookup_t;

    localparam logic [24:0] MSK_BOOT = 25'h0003FFF;
    localparam logic [24:0] MSK_WRAM = 25'h003FFFF;
    localparam logic [24:0] MSK_IRAM = 25'h0007FFF;
    localparam logic [24:0] MSK_SMALL = 25'h00003FF;
    localparam logic [24:0] MSK_VRAM = 25'h001FFFF;
    localparam logic [24:0] MSK_CART = 25'h1FFFFFF;
    localparam logic [3:0]  ID_CART = 4'd8;
    localparam logic [31:0] STORE_SALT = 32'h5A3C9600;

    function automatic logic [24:0] mirror_mask(logic [3:0] id);
        case (id)
            4'h0: return MSK_BOOT;
            4'h2: return MSK_WRAM;
            4'h3: return MSK_IRAM;
            4'h4, 4'h5, 4'h7: return MSK_SMALL;
            4'h6: return MSK_VRAM;
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC: return MSK_CART;
            default: return 25'h0;
        endcase
    endfunction

    function automatic logic [3:0] content_id(logic [3:0] id);
        if (id >= 4'h8 && id <= 4'hC) return ID_CART;
        return id;
    endfunction

    function automatic logic [31:0] store_word(logic [3:0] id, logic [24:0] off);
        logic [23:0] w;
        w = {1'b0, off[24:2]};
        return {w[7:0], w} ^ {id, 28'h0} ^ STORE_SALT;
    endfunction

    function automatic logic [31:0] ror32(logic [31:0] v, logic [4:0] n);
        return (v >> n) | (v << (6'd32 - {1'b0, n}));
    endfunction

endpackage

// File: rtl/rd_region_decode.sv
module rd_region_decode
    import bus_rd_pkg::*;
#(
    parameter int IO_FLAGS = 512
) (
    input  logic [31:0]         addr,
    input  logic [1:0]          size,
    input  logic [7:0]          pc_hi,
    input  logic [2:0]          disp_mode,
    input  logic [IO_FLAGS-1:0] io_readable,
    input  logic                ee_en,
    input  logic                fl_en,
    output lookup_t             lk
);
    localparam int IO_IW = $clog2(IO_FLAGS);

    logic [IO_IW-1:0] io_lo_idx;
    logic [IO_IW-1:0] io_hi_idx;
    logic             io_ok;
    logic             io_flag;
    logic [16:0]      v_off;

    always_comb begin
        io_lo_idx = {addr[IO_IW:2], 1'b0};
        io_hi_idx = {addr[IO_IW:2], 1'b1};
        io_flag   = size[1] ? io_readable[io_lo_idx] : io_readable[addr[IO_IW:1]];
        io_ok     = (addr[23:IO_IW+1] == '0) && io_flag;
        v_off     = addr[16:0];

        lk = '{src: SRC_OPEN, id: content_id(addr[27:24]),
               off: addr[24:0] & mirror_mask(addr[27:24]), low_only: 1'b0};

        if (addr[31:28] == 4'h0) begin
            case (addr[27:24])
                4'h0: begin
                    if (pc_hi != 8'h0) begin
                        if (addr[23:14] == '0) lk.src = SRC_GUARD;
                    end else begin
                        lk.src = SRC_STORE;
                    end
                end
                4'h2, 4'h3, 4'h5, 4'h7,
                4'h8, 4'h9, 4'hA, 4'hB, 4'hC: lk.src = SRC_STORE;
                4'h4: begin
                    if (io_ok) begin
                        lk.src      = SRC_STORE;
                        lk.low_only = size[1] && !io_readable[io_hi_idx];
                    end
                end
                4'h6: begin
                    if (disp_mode > 3'd2 && v_off[16:14] == 3'b110) begin
                        lk.src = SRC_ZERO;
                    end else begin
                        lk.src = SRC_STORE;
                        if (v_off[16:15] == 2'b11) v_off[15] = 1'b0;
                        lk.off = {8'h0, v_off};
                    end
                end
                4'hD: if (ee_en) lk.src = SRC_ONES;
                4'hE: if (fl_en) lk.src = SRC_ONES;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rd_open_bus.sv
module rd_open_bus
    import bus_rd_pkg::*;
(
    input  logic [31:0] pc,
    input  logic        cpu_narrow,
    input  logic        dma_ovr,
    input  logic [31:0] dma_last,
    output logic [31:0] ob_word
);
    logic [3:0]  pid;
    logic [31:0] opc;
    logic [15:0] half;

    always_comb begin
        pid  = (pc[31:28] == 4'h0) ? pc[27:24] : 4'hF;
        opc  = store_word(content_id(pid), pc[24:0] & mirror_mask(pid));
        half = pc[1] ? opc[31:16] : opc[15:0];
        if (dma_ovr)         ob_word = dma_last;
        else if (cpu_narrow) ob_word = {half, half};
        else                 ob_word = opc;
    end
endmodule

// File: rtl/rd_lane_align.sv
module rd_lane_align
    import bus_rd_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic        sgn,
    output logic [31:0] data
);
    logic [7:0]  b;
    logic [15:0] h;

    always_comb begin
        b = 8'(word >> {lane, 3'b000});
        h = lane[1] ? word[31:16] : word[15:0];
        case (acc_size_e'(size))
            SZ_BYTE: data = sgn ? {{24{b[7]}}, b} : {24'h0, b};
            SZ_HALF: begin
                if (lane[0])
                    data = sgn ? {{24{h[15]}}, h[15:8]} : {h[7:0], 16'h0, h[15:8]};
                else
                    data = sgn ? {{16{h[15]}}, h} : {16'h0, h};
            end
            default: data = ror32(word, {lane, 3'b000});
        endcase
    end
endmodule

// File: rtl/bus_rd_decode.sv
module bus_rd_decode
    import bus_rd_pkg::*;
#(
    parameter int IO_FLAGS = 512
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [31:0]         req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic [31:0]         pc,
    input  logic                cpu_narrow,
    input  logic [2:0]          disp_mode,
    input  logic                dma_ovr,
    input  logic [31:0]         dma_last,
    input  logic [31:0]         guard_word,
    input  logic [IO_FLAGS-1:0] io_readable,
    input  logic                nv_eeprom_en,
    input  logic                nv_flash_en,
    output logic                rd_valid,
    output logic [31:0]         rd_data
);
    lookup_t     lk;
    logic [31:0] ob_word;
    logic [31:0] src_word;
    logic [31:0] raw_store;
    logic [31:0] aligned;

    rd_region_decode #(.IO_FLAGS(IO_FLAGS)) u_dec (
        .addr        (req_addr),
        .size        (req_size),
        .pc_hi       (pc[31:24]),
        .disp_mode   (disp_mode),
        .io_readable (io_readable),
        .ee_en       (nv_eeprom_en),
        .fl_en       (nv_flash_en),
        .lk          (lk)
    );

    rd_open_bus u_ob (
        .pc         (pc),
        .cpu_narrow (cpu_narrow),
        .dma_ovr    (dma_ovr),
        .dma_last   (dma_last),
        .ob_word    (ob_word)
    );

    always_comb begin
        raw_store = store_word(lk.id, lk.off);
        if (lk.low_only) raw_store = {16'h0, raw_store[15:0]};
        case (lk.src)
            SRC_STORE: src_word = raw_store;
            SRC_GUARD: src_word = guard_word;
            SRC_ZERO:  src_word = 32'h0;
            SRC_ONES:  src_word = 32'hFFFF_FFFF;
            default:   src_word = ob_word;
        endcase
    end

    rd_lane_align u_align (
        .word (src_word),
        .lane (req_addr[1:0]),
        .size (req_size),
        .sgn  (req_signed),
        .data (aligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= req;
            if (req) rd_data <= aligned;
        end
    end
endmodule

// File: rtl/bus_rd_decode_chk.sv
module bus_rd_decode_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_signed,
    input logic [2:0]  disp_mode,
    input logic        dma_ovr,
    input logic [31:0] dma_last,
    input logic        nv_eeprom_en,
    input logic        rd_valid,
    input logic [31:0] rd_data
);
    // R1: strobe follows a request by one cycle
    p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        req |=> rd_valid);

    // R1: no strobe without a request
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rd_valid);

    // R5: dead zone in bitmap modes reads as zero
    p_hole_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (req && req_addr[31:24] == 8'h06 && disp_mode > 3'd2 && req_addr[16:14] == 3'b110)
        |=> rd_data == 32'h0);

    // R9: unsigned byte has clear upper bits
    p_byte_zext_r9: assert property (@(posedge clk) disable iff (rst)
        (req && req_size == 2'd0 && !req_signed) |=> rd_data[31:8] == 24'h0);

    // R10: aligned word open-bus read returns the DMA word under override
    p_dma_word_r10: assert property (@(posedge clk) disable iff (rst)
        (req && req_addr[31:24] == 8'h01 && dma_ovr && req_size == 2'd2 && req_addr[1:0] == 2'd0)
        |=> rd_data == $past(dma_last));

    // R11: enabled EEPROM window reads all-ones for word accesses
    p_nv_ones_r11: assert property (@(posedge clk) disable iff (rst)
        (req && req_addr[31:24] == 8'h0D && nv_eeprom_en && req_size[1])
        |=> rd_data == 32'hFFFF_FFFF);
endmodule

bind bus_rd_decode bus_rd_decode_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_signed   (req_signed),
    .disp_mode    (disp_mode),
    .dma_ovr      (dma_ovr),
    .dma_last     (dma_last),
    .nv_eeprom_en (nv_eeprom_en),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
);

// File: tb/sim_bus_rd_decode.sv
`timescale 1ns/1ps
module sim_bus_rd_decode;
    localparam int IO_FLAGS = 512;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req = 1'b0;
    logic [31:0]         req_addr = '0;
    logic [1:0]          req_size = '0;
    logic                req_signed = 1'b0;
    logic [31:0]         pc = 32'h0800_0100;
    logic                cpu_narrow = 1'b0;
    logic [2:0]          disp_mode = 3'd0;
    logic                dma_ovr = 1'b0;
    logic [31:0]         dma_last = 32'hC0DE_1234;
    logic [31:0]         guard_word = 32'hE3A0_2A81;
    logic [IO_FLAGS-1:0] io_readable;
    logic                nv_eeprom_en = 1'b0;
    logic                nv_flash_en = 1'b0;
    logic                rd_valid;
    logic [31:0]         rd_data;

    int    checks = 0;
    int    errors = 0;
    bit    armed = 0;
    bit    done = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";
    logic        exp_valid = 1'b0;
    logic [31:0] exp_data = 32'h0;

    always #4 clk = ~clk;

    bus_rd_decode #(.IO_FLAGS(IO_FLAGS)) u0 (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_size(req_size),
        .req_signed(req_signed), .pc(pc), .cpu_narrow(cpu_narrow), .disp_mode(disp_mode),
        .dma_ovr(dma_ovr), .dma_last(dma_last), .guard_word(guard_word),
        .io_readable(io_readable), .nv_eeprom_en(nv_eeprom_en), .nv_flash_en(nv_flash_en),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [31:0] pat(int id, logic [31:0] off);
        logic [31:0] w;
        w = (off >> 2) & 32'h007F_FFFF;
        return ((w << 24) | w) ^ (32'(id) << 28) ^ 32'h5A3C_9600;
    endfunction

    function automatic logic [31:0] msk(int id);
        if (id == 0) return 32'h3FFF;
        if (id == 2) return 32'h3FFFF;
        if (id == 3) return 32'h7FFF;
        if (id == 4 || id == 5 || id == 7) return 32'h3FF;
        if (id == 6) return 32'h1FFFF;
        if (id >= 8 && id <= 12) return 32'h1FF_FFFF;
        return 32'h0;
    endfunction

    function automatic logic [31:0] open_bus();
        int pid, cid;
        logic [31:0] op, h;
        pid = ((pc >> 28) != 0) ? 15 : int'((pc >> 24) & 15);
        cid = (pid >= 8 && pid <= 12) ? 8 : pid;
        op  = pat(cid, pc & msk(pid));
        h   = pc[1] ? (op >> 16) : (op & 32'hFFFF);
        if (dma_ovr) return dma_last;
        if (cpu_narrow) return (h << 16) | h;
        return op;
    endfunction

    function automatic logic [31:0] model(logic [31:0] a, int sz, bit sg);
        int top, hw, sh;
        bit unm;
        logic [31:0] w, o, h, b;
        top = int'(a >> 24);
        unm = 0;
        w = 0;
        if (top == 0) begin
            if ((pc >> 24) != 0) begin
                if (a < 32'h4000) w = guard_word; else unm = 1;
            end else w = pat(0, a & msk(0));
        end else if (top == 2 || top == 3 || top == 5 || top == 7) begin
            w = pat(top, a & msk(top));
        end else if (top == 4) begin
            hw = int'((a & 32'h3FF) >> 1);
            if (a >= 32'h0400_0400) unm = 1;
            else if (sz >= 2) begin
                if (!io_readable[hw & ~1]) unm = 1;
                else begin
                    w = pat(4, a & 32'h3FF);
                    if (!io_readable[hw | 1]) w = w & 32'hFFFF;
                end
            end else if (!io_readable[hw]) unm = 1;
            else w = pat(4, a & 32'h3FF);
        end else if (top == 6) begin
            o = a & 32'h1FFFF;
            if (disp_mode > 2 && ((o >> 14) & 7) == 6) w = 0;
            else begin
                if (((o >> 15) & 3) == 3) o = o & 32'h17FFF;
                w = pat(6, o);
            end
        end else if (top >= 8 && top <= 12) begin
            w = pat(8, a & 32'h1FF_FFFF);
        end else if (top == 13 && nv_eeprom_en) w = 32'hFFFF_FFFF;
        else if (top == 14 && nv_flash_en) w = 32'hFFFF_FFFF;
        else unm = 1;
        if (unm) w = open_bus();

        sh = int'(a & 3) * 8;
        if (sz == 0) begin
            b = (w >> sh) & 32'hFF;
            if (sg && b[7]) b = b | 32'hFFFF_FF00;
            return b;
        end else if (sz == 1) begin
            h = a[1] ? (w >> 16) : (w & 32'hFFFF);
            if (a[0]) begin
                if (sg) return (h[15]) ? (32'hFFFF_FF00 | (h >> 8)) : (h >> 8);
                return (h >> 8) | ((h & 32'hFF) << 24);
            end
            if (sg && h[15]) return h | 32'hFFFF_0000;
            return h;
        end
        if (sh == 0) return w;
        return (w >> sh) | (w << (32 - sh));
    endfunction

    // ---------------- scoreboard ----------------
    always @(posedge clk) begin
        armed <= 1'b1;
        if (rst) begin
            exp_valid <= 1'b0;
            exp_data  <= 32'h0;
            exp_tag   <= "R1";
        end else begin
            exp_valid <= req;
            if (req) begin
                exp_data <= model(req_addr, int'(req_size), req_signed);
                exp_tag  <= cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (rd_valid !== exp_valid || rd_data !== exp_data) begin
                errors++;
                $display("FAIL %s: valid=%0b data=%08h expected valid=%0b data=%08h",
                         exp_tag, rd_valid, rd_data, exp_valid, exp_data);
            end
        end
    end

    task automatic rd(input logic [31:0] a, input int sz, input bit sg, input string tag);
        @(negedge clk);
        req        = 1'b1;
        req_addr   = a;
        req_size   = 2'(sz);
        req_signed = sg;
        cur_tag    = tag;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        io_readable = '1;
        io_readable[3] = 1'b0;
        io_readable[5] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);   // reset state compared as R1

        // R2 R3: regions, content and mirroring
        rd(32'h0200_0010, 2, 0, "R2 work RAM");
        rd(32'h0204_0010, 2, 0, "R3 work RAM mirror");
        rd(32'h0300_8004, 2, 0, "R3 internal RAM mirror");
        rd(32'h0500_0404, 2, 0, "R3 palette mirror");
        rd(32'h0700_0808, 2, 0, "R3 object memory mirror");
        rd(32'h0C00_0020, 2, 0, "R2 cartridge alias");
        rd(32'h0A20_0040, 2, 0, "R3 cartridge mask");

        // R4: guarded boot ROM
        rd(32'h0000_0008, 2, 0, "R4 guard word");
        rd(32'h0000_0002, 0, 0, "R4 guard byte");
        rd(32'h0000_0002, 1, 0, "R4 guard half");
        rd(32'h0000_4000, 2, 0, "R4 above guard unmapped");
        pc = 32'h0000_0100;
        rd(32'h0000_4004, 2, 0, "R3 boot mirror");
        rd(32'h0000_0008, 2, 0, "R4 no guard inside boot");
        pc = 32'h0800_0100;

        // R5: video RAM fold and dead zone
        rd(32'h0601_8010, 2, 0, "R5 fold mode0");
        rd(32'h0601_C000, 2, 0, "R5 fold top");
        disp_mode = 3'd3;
        rd(32'h0601_8010, 2, 0, "R5 hole mode3");
        rd(32'h0601_8013, 0, 1, "R5 hole byte");
        rd(32'h0601_C010, 2, 0, "R5 fold mode3");
        rd(32'h0601_4000, 2, 0, "R5 plain bank");
        disp_mode = 3'd2;
        rd(32'h0601_8010, 2, 0, "R5 mode2 no hole");
        disp_mode = 3'd0;

        // R6: I/O
        rd(32'h0400_0000, 2, 0, "R6 io full word");
        rd(32'h0400_0004, 2, 0, "R6 io low half only");
        rd(32'h0400_0006, 1, 0, "R6 io half unreadable");
        rd(32'h0400_000A, 1, 0, "R6 io flag clear");
        rd(32'h0400_0009, 0, 0, "R6 io byte readable");
        rd(32'h0400_0400, 2, 0, "R6 io beyond window");

        // R7: word rotation
        rd(32'h0200_0011, 2, 0, "R7 rot8");
        rd(32'h0200_0012, 2, 1, "R7 rot16 signed ignored");
        rd(32'h0200_0013, 3, 0, "R7 rot24 size3");

        // R8 R9: halfwords and bytes
        rd(32'h0300_0002, 1, 0, "R8 half upper");
        rd(32'h0300_0003, 1, 0, "R8 half odd");
        rd(32'h0300_0003, 1, 1, "R9 signed odd half");
        rd(32'h0300_0002, 1, 1, "R9 signed even half");
        rd(32'h0300_0001, 0, 1, "R9 signed byte");
        rd(32'h0300_0003, 0, 0, "R9 byte lane3");
        rd(32'h0200_0010, 0, 1, "R9 signed byte lane0");

        // R10: open bus
        rd(32'h0100_0000, 2, 0, "R10 open wide state");
        rd(32'h0100_0002, 1, 0, "R10 open wide half");
        cpu_narrow = 1'b1;
        pc = 32'h0800_0102;
        rd(32'h0100_0000, 2, 0, "R10 open narrow state");
        rd(32'h0100_0003, 0, 0, "R10 open narrow byte");
        pc = 32'h0600_0100;
        rd(32'h0F00_0001, 1, 0, "R10 open pc in video");
        dma_ovr = 1'b1;
        rd(32'h0100_0000, 2, 0, "R10 dma word");
        rd(32'h0100_0001, 2, 0, "R10 dma rotated");
        rd(32'h1000_0002, 0, 0, "R10 dma byte");
        dma_ovr = 1'b0;
        cpu_narrow = 1'b0;
        pc = 32'h0800_0100;

        // R11: backup windows
        rd(32'h0D00_0000, 2, 0, "R11 eeprom off");
        nv_eeprom_en = 1'b1;
        rd(32'h0D00_0000, 2, 0, "R11 eeprom on");
        rd(32'h0E00_0001, 0, 0, "R11 flash off");
        nv_flash_en = 1'b1;
        rd(32'h0E00_0001, 0, 0, "R11 flash on byte");
        rd(32'h8000_0000, 2, 0, "R11 high unmapped");

        // R1: back-to-back requests and hold
        @(negedge clk);
        req = 1'b1; req_addr = 32'h0200_0020; req_size = 2'd2; req_signed = 1'b0; cur_tag = "R1 b2b first";
        @(negedge clk);
        req_addr = 32'h0200_0024; cur_tag = "R1 b2b second";
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule